// File: doc/BRIEF.md
# Peripheral Bus Timeout Monitor

This block sits between the masters of a request/ready peripheral register bus and the slave side. Requests, ready and error responses normally pass straight through. While an access is outstanding and the slave holds ready low, the block counts wait cycles. When that count reaches a programmed limit, the block ends the access itself. It sends the master a one-cycle error response and masks the request toward the slave. It also raises a sticky interrupt and records the address of the failed access, together with the master's ID and permission level.

Software sets the limit and the protection switch through a four-word register window. It reads the captured address and identity there and acknowledges the interrupt with a write-trigger bit. Clearing the interrupt zeroes the captured identity. The captured address is kept. While an interrupt is pending, later timeouts still end their accesses with an error, but the first capture is kept.

The control path is a three-state machine. `ST_IDLE` means no wait cycle has been counted. `ST_PEND` means an access is outstanding and waiting. `ST_ERR` is the single cycle in which the error response is driven. The transitions are as follows:
- idle-to-pend: a wait cycle below the limit.
- pend-to-pend: a further wait cycle below the limit.
- idle/pend-to-idle: the slave gives ready, or the master drops its request.
- idle/pend-to-err: a wait cycle finds the count at or above the limit while protection is on.
- err-to-idle: always, after one cycle.

Top module: `bus_timeout_monitor`

## Requirements
- R1: After reset, the limit is 65535 and protection is enabled, so register word 0 reads 0x0002FFFF. The interrupt is low, and words 1 and 2 read zero.
- R2: When no timeout occurs, `slv_req` follows `mst_req`, `mst_ready` follows `slv_ready` and `mst_err` follows `slv_err`. The wait count restarts for every access, so an access that completes within the limit passes through unchanged.
- R3: Take a limit T with protection enabled and a request first presented in cycle k whose slave never gives ready through cycle k+T. In cycle k+T+1 the block drives `mst_ready`=1 and `mst_err`=1 for exactly one cycle, and `slv_req` is 0 in that cycle. With T=0 this happens in cycle k+1. A slave ready in cycle k+T is still passed through normally.
- R4: `irq` rises in the same cycle as the timeout error response and stays high until it is cleared.
- R5: On a timeout with no interrupt pending, word 1 captures the full access address. Word 2 captures the identity, with the master ID in bits [4:0] and the permission level in bits [6:5].
- R6: A write to word 0 with bit 16 set clears `irq` and zeroes word 2 from the next cycle. Word 1 keeps its value, and bit 16 always reads 0.
- R7: While `irq` is pending, further timeouts still produce error responses, but words 1 and 2 keep their first capture.
- R8: With protection disabled (word 0 bit 17 = 0), no timeout occurs however long the slave stalls.
- R9: The register word index is `reg_idx`. Word 0 holds the limit in [15:0], clear in [16] and enable in [17]. Words 1 and 2 are read-only, and writes to them are ignored. Word 3 reads 0.
- R10: A clear written in the same cycle that a timeout is detected leaves `irq` high, and words 1 and 2 take the new access's capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitored bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_req | input | 1 | Master request, held until ready |
| mst_addr | input | 32 | Access address |
| mst_id | input | 5 | Requesting master ID |
| mst_perm | input | 2 | Requesting master permission level |
| mst_ready | output | 1 | Response valid toward the master |
| mst_err | output | 1 | Error response toward the master |
| slv_req | output | 1 | Request toward the slave |
| slv_ready | input | 1 | Slave response valid |
| slv_err | input | 1 | Slave error response |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Sticky timeout interrupt |

## Verification
Pass-through responses and register reads are combinational, so they are due in the same cycle as their inputs. A timeout response and the rising interrupt are due T+1 cycles after the request first appears. Register writes and clears take effect on the next cycle. The scoreboard queues, for each access, the expected latency in cycles and the expected error flag and timeout kind. The monitor counts the cycles of each access at the falling edge and compares them when `mst_ready` appears. A clear can be injected into a chosen wait cycle, which places it exactly on the detection edge.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_ERR  = 2'd2
    } tmo_state_e;

    localparam int IDX_W = 2;
    localparam logic [IDX_W-1:0] IDX_CTRL = 2'd0;
    localparam logic [IDX_W-1:0] IDX_ADDR = 2'd1;
    localparam logic [IDX_W-1:0] IDX_UID  = 2'd2;

endpackage

// File: rtl/tmo_cfg_regs.sv
module tmo_cfg_regs
    import tmo_pkg::*;
#(
    parameter int DATA_W            = 32,
    parameter int THR_W             = 16,
    parameter logic [THR_W-1:0] THR_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [THR_W-1:0]  thres_o,
    output logic              en_o,
    output logic              clr_o
);
    localparam int CLR_BIT = THR_W;
    localparam int EN_BIT  = THR_W + 1;

    logic ctrl_wr;

    assign ctrl_wr = wr_i && (idx_i == IDX_CTRL);
    assign clr_o   = ctrl_wr && wdata_i[CLR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thres_o <= THR_RST;
            en_o    <= 1'b1;
        end else if (ctrl_wr) begin
            thres_o <= wdata_i[THR_W-1:0];
            en_o    <= wdata_i[EN_BIT];
        end
    end

    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> ($stable(thres_o) && $stable(en_o)));

endmodule

// File: rtl/tmo_fsm.sv
module tmo_fsm
    import tmo_pkg::*;
#(
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             ready_i,
    input  logic             en_i,
    input  logic [THR_W-1:0] thres_i,
    output logic             fire_o,
    output logic             abort_o
);
    tmo_state_e       st_q, st_n;
    logic [THR_W-1:0] cnt_q, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        st_n   = st_q;
        cnt_n  = cnt_q;
        fire_o = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_PEND: begin
                if (!req_i || ready_i) begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end else if (en_i && (cnt_q >= thres_i)) begin
                    st_n   = ST_ERR;
                    cnt_n  = '0;
                    fire_o = 1'b1;
                end else begin
                    st_n  = ST_PEND;
                    cnt_n = en_i ? cnt_q + 1'b1 : cnt_q;
                end
            end
            ST_ERR: begin
                st_n  = ST_IDLE;
                cnt_n = '0;
            end
            default: begin
                st_n  = ST_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    always_comb begin
        abort_o = (st_q == ST_ERR);
    end

    // R3
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ERR) |=> (st_q != ST_ERR));

    // R8
    no_abort_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && st_q != ST_ERR) |=> (st_q != ST_ERR));

    // R2
    idle_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (cnt_q == '0));

endmodule

// File: rtl/tmo_capture.sv
module tmo_capture #(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 5,
    parameter int PERM_W = 2,
    localparam int UID_W = ID_W + PERM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic              clr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic [PERM_W-1:0] perm_i,
    output logic              irq_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [UID_W-1:0]  uid_o
);
    logic take;

    assign take = fire_i && (!irq_o || clr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o  <= 1'b0;
            addr_o <= '0;
            uid_o  <= '0;
        end else begin
            if (fire_i)     irq_o <= 1'b1;
            else if (clr_i) irq_o <= 1'b0;
            if (take)       addr_o <= addr_i;
            if (take)       uid_o  <= {perm_i, id_i};
            else if (clr_i) uid_o  <= '0;
        end
    end

    // R5
    capture_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (addr_o == $past(addr_i)));

    // R6
    clear_uid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !fire_i) |=> (!irq_o && uid_o == '0));

    // R7
    first_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_i) |=> ($stable(addr_o) && $stable(uid_o)));

endmodule

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor
    import tmo_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int THR_W   = 16,
    parameter int ID_W    = 5,
    parameter int PERM_W  = 2,
    parameter logic [THR_W-1:0] THR_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mst_req,
    input  logic [DATA_W-1:0] mst_addr,
    input  logic [ID_W-1:0]   mst_id,
    input  logic [PERM_W-1:0] mst_perm,
    output logic              mst_ready,
    output logic              mst_err,
    output logic              slv_req,
    input  logic              slv_ready,
    input  logic              slv_err,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int UID_W = ID_W + PERM_W;

    logic [THR_W-1:0]  thres;
    logic              en, clr, fire, abort;
    logic [DATA_W-1:0] cap_addr;
    logic [UID_W-1:0]  cap_uid;

    tmo_cfg_regs #(.DATA_W(DATA_W), .THR_W(THR_W), .THR_RST(THR_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .idx_i(reg_idx),
        .wdata_i(reg_wdata), .thres_o(thres), .en_o(en), .clr_o(clr)
    );

    tmo_fsm #(.THR_W(THR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_i(mst_req), .ready_i(slv_ready),
        .en_i(en), .thres_i(thres), .fire_o(fire), .abort_o(abort)
    );

    tmo_capture #(.ADDR_W(DATA_W), .ID_W(ID_W), .PERM_W(PERM_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .clr_i(clr),
        .addr_i(mst_addr), .id_i(mst_id), .perm_i(mst_perm),
        .irq_o(irq), .addr_o(cap_addr), .uid_o(cap_uid)
    );

    always_comb begin
        slv_req   = mst_req && !abort;
        mst_ready = abort ? 1'b1 : slv_ready;
        mst_err   = abort ? 1'b1 : slv_err;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_idx)
            IDX_CTRL: reg_rdata = {{(DATA_W-THR_W-2){1'b0}}, en, 1'b0, thres};
            IDX_ADDR: reg_rdata = cap_addr;
            IDX_UID:  reg_rdata = {{(DATA_W-UID_W){1'b0}}, cap_uid};
            default:  reg_rdata = '0;
        endcase
    end

    // R4
    irq_with_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (mst_ready && mst_err && !slv_req));

endmodule

// File: tb/bus_timeout_monitor_tb.sv
`timescale 1ns/1ps
module bus_timeout_monitor_tb;
    logic        clk = 0, rst_n = 0;
    logic        mst_req = 0, slv_ready = 0, slv_err = 0, reg_wr = 0;
    logic [31:0] mst_addr = 0, reg_wdata = 0;
    logic [4:0]  mst_id = 0;
    logic [1:0]  mst_perm = 0, reg_idx = 0;
    logic        mst_ready, mst_err, slv_req, irq;
    logic [31:0] reg_rdata;

    int n_chk = 0, n_fail = 0, lat = 0;
    logic [17:0] exp_q[$];   // {timeout, err, latency}

    bus_timeout_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .mst_addr(mst_addr),
        .mst_id(mst_id), .mst_perm(mst_perm), .mst_ready(mst_ready),
        .mst_err(mst_err), .slv_req(slv_req), .slv_ready(slv_ready),
        .slv_err(slv_err), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    // monitor: pops expected response per access
    always @(negedge clk) begin
        if (rst_n && mst_req) begin
            if (mst_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected response", 32'd1, 32'd0);
                end else begin
                    logic [17:0] e;
                    e = exp_q.pop_front();
                    chk(mst_err == e[16], "R2/R3 error flag", {31'd0, mst_err}, {31'd0, e[16]});
                    chk(lat == int'(e[15:0]), "R2/R3 latency", lat, {16'd0, e[15:0]});
                    if (e[17]) begin
                        chk(irq == 1'b1, "R4 irq with error", {31'd0, irq}, 32'd1);
                        chk(slv_req == 1'b0, "R3 slave masked", {31'd0, slv_req}, 32'd0);
                    end else begin
                        chk(slv_req == 1'b1, "R2 request passed", {31'd0, slv_req}, 32'd1);
                    end
                end
                lat = 0;
            end else lat++;
        end else lat = 0;
    end

    task automatic access(input logic [31:0] a, input logic [4:0] id, input logic [1:0] pm,
                          input int d, input bit serr, input int t, input bit en,
                          input int clr_at, input logic [31:0] clr_word);
        bit tmo;
        bit done;
        int cyc;
        tmo = en && (d > t);
        exp_q.push_back({tmo, tmo ? 1'b1 : serr, tmo ? 16'(t + 1) : 16'(d)});
        @(posedge clk); #1;
        mst_req = 1; mst_addr = a; mst_id = id; mst_perm = pm;
        cyc = 0; done = 0;
        while (!done) begin
            slv_ready = (cyc == d);
            slv_err   = serr && (cyc == d);
            if (cyc == clr_at) begin
                reg_wr = 1; reg_idx = 0; reg_wdata = clr_word;
            end else reg_wr = 0;
            @(negedge clk);
            done = mst_ready;
            @(posedge clk); #1;
            cyc++;
        end
        mst_req = 0; slv_ready = 0; slv_err = 0; reg_wr = 0;
    endtask

    task automatic reg_write(input logic [1:0] i, input logic [31:0] v);
        @(posedge clk); #1;
        reg_wr = 1; reg_idx = i; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic reg_read(input logic [1:0] i, output logic [31:0] v);
        @(posedge clk); #1;
        reg_idx = i;
        @(negedge clk);
        v = reg_rdata;
    endtask

    logic [31:0] rv;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state, R9 word 3
        reg_read(0, rv); chk(rv == 32'h0002FFFF, "R1 ctrl reset", rv, 32'h0002FFFF);
        reg_read(1, rv); chk(rv == 0, "R1 addr reset", rv, 0);
        reg_read(2, rv); chk(rv == 0, "R1 uid reset", rv, 0);
        reg_read(3, rv); chk(rv == 0, "R9 word3", rv, 0);
        chk(irq == 0, "R1 irq reset", {31'd0, irq}, 0);

        // R2 pass-through below the limit
        reg_write(0, 32'h0002_0004);
        access(32'h1000, 5'd1, 2'd0, 0, 0, 4, 1, -1, 0);
        access(32'h1004, 5'd2, 2'd1, 2, 0, 4, 1, -1, 0);
        access(32'h1008, 5'd3, 2'd2, 4, 0, 4, 1, -1, 0);
        access(32'h100C, 5'd4, 2'd3, 1, 1, 4, 1, -1, 0);
        chk(irq == 0, "R2 no irq", {31'd0, irq}, 0);

        // R3/R5 timeout and capture
        access(32'hDEAD_BEE0, 5'd19, 2'd2, 8, 0, 4, 1, -1, 0);
        reg_read(1, rv); chk(rv == 32'hDEAD_BEE0, "R5 addr capture", rv, 32'hDEAD_BEE0);
        reg_read(2, rv); chk(rv == {25'd0, 2'd2, 5'd19}, "R5 uid capture", rv, {25'd0, 2'd2, 5'd19});

        // R7 second timeout keeps first capture
        access(32'h0000_5550, 5'd7, 2'd1, 9, 0, 4, 1, -1, 0);
        reg_read(1, rv); chk(rv == 32'hDEAD_BEE0, "R7 addr kept", rv, 32'hDEAD_BEE0);
        reg_read(2, rv); chk(rv == {25'd0, 2'd2, 5'd19}, "R7 uid kept", rv, {25'd0, 2'd2, 5'd19});

        // R9 read-only words ignore writes
        reg_write(1, 32'h1234_5678);
        reg_write(2, 32'h0000_007F);
        reg_read(1, rv); chk(rv == 32'hDEAD_BEE0, "R9 addr read-only", rv, 32'hDEAD_BEE0);
        reg_read(2, rv); chk(rv == {25'd0, 2'd2, 5'd19}, "R9 uid read-only", rv, {25'd0, 2'd2, 5'd19});
        // R4 sticky
        chk(irq == 1, "R4 irq sticky", {31'd0, irq}, 1);

        // R6 clear
        reg_write(0, 32'h0003_0004);
        chk(irq == 0, "R6 irq cleared", {31'd0, irq}, 0);
        reg_read(2, rv); chk(rv == 0, "R6 uid cleared", rv, 0);
        reg_read(1, rv); chk(rv == 32'hDEAD_BEE0, "R6 addr kept", rv, 32'hDEAD_BEE0);
        reg_read(0, rv); chk(rv == 32'h0002_0004, "R6 clear bit reads 0", rv, 32'h0002_0004);

        // R3 limit zero
        reg_write(0, 32'h0002_0000);
        access(32'h0000_A000, 5'd31, 2'd3, 3, 0, 0, 1, -1, 0);
        reg_read(2, rv); chk(rv == {25'd0, 2'd3, 5'd31}, "R3 zero-limit capture", rv, {25'd0, 2'd3, 5'd31});

        // R10 clear on the detection edge
        reg_write(0, 32'h0003_0003);
        access(32'h0000_B000, 5'd5, 2'd0, 10, 0, 3, 1, -1, 0);
        access(32'h0000_C000, 5'd9, 2'd1, 10, 0, 3, 1, 3, 32'h0003_0003);
        chk(irq == 1, "R10 irq stays", {31'd0, irq}, 1);
        reg_read(1, rv); chk(rv == 32'h0000_C000, "R10 new addr", rv, 32'h0000_C000);
        reg_read(2, rv); chk(rv == {25'd0, 2'd1, 5'd9}, "R10 new uid", rv, {25'd0, 2'd1, 5'd9});

        // R8 disabled protection
        reg_write(0, 32'h0001_0002);
        access(32'h0000_D000, 5'd6, 2'd2, 20, 0, 2, 0, -1, 0);
        chk(irq == 0, "R8 no irq when disabled", {31'd0, irq}, 0);
        reg_read(1, rv); chk(rv == 32'h0000_C000, "R8 no capture", rv, 32'h0000_C000);

        repeat (3) @(posedge clk);
        chk(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
        finish_run();
    end
endmodule